// File: doc/BRIEF.md
# Dual-Select Static Word Memory with Write-Through Output

This block is a clocked model of a small static memory: 256 words of 4 bits, an 8-bit address, an input data bus and a separate output data bus. Access is gated by two chip selects of opposite polarity. One is active low and one is active high, so a bank can be chosen from a decoded address without an extra inverter. An active-low write strobe and an active-low output enable complete the controls. The pins that a discrete part would three-state are modelled here as a 4-bit data word and a drive flag. When the flag is low, the data word is forced to zero.

The four control pins select one of five modes. Two are standby modes, one for each deselecting chip select. The other three are output-muted, read and write. A write is committed on the rising clock edge. The same edge also loads the written word into the output data register. If a read of that location follows, the outputs already carry the correct word in the read's first cycle. Any other read shows the addressed word from the cycle after the address is presented. The drive flag follows the control pins in the same cycle. No clock activity is needed to keep the contents, and every access takes one cycle.

The control pins are plain levels with no handshake. The block accepts a new access every cycle and never stalls, so there is no back-pressure to manage.

Top module: `sram_dual_sel`

## Requirements
- R1: While `cs_hi` is low, `dout_drive` is 0 and `dout` is 0 in that same cycle, whatever the other controls are. A write attempted in this state leaves memory unchanged.
- R2: While `cs_lo_n` is high, `dout_drive` is 0 and `dout` is 0 in that same cycle, whatever the other controls are. A write attempted in this state leaves memory unchanged.
- R3: With both selects active, `wr_n` high and `oe_n` high, the outputs are not driven (`dout_drive`=0, `dout`=0).
- R4: With both selects active and `wr_n` low, `din` is stored at `addr` on the rising edge. In that cycle the outputs are not driven, for either value of `oe_n`.
- R5: With both selects active, `wr_n` high and `oe_n` low, `dout_drive` is 1 in that cycle. From the next cycle on, `dout` carries the word stored at `addr`, not inverted.
- R6: In the cycle after a write, a read shows the word just written on `dout` at once.
- R7: Whenever `dout_drive` is 0, `dout` is 0.
- R8: Reset clears the output data register. A read in the first cycle after reset shows `dout`=0 with `dout_drive`=1.
- R9: All 256 locations hold independent words. Writing every address and reading each back returns its own value.
- R10: Cycles that are neither reads nor writes leave the output data register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset of the output register |
| addr | input | 8 | Word address |
| din | input | 4 | Write data |
| cs_lo_n | input | 1 | Chip select, active low |
| cs_hi | input | 1 | Chip select, active high |
| wr_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| dout | output | 4 | Read data, 0 when not driven |
| dout_drive | output | 1 | High when the outputs would be driven |

## Verification
The drive flag is due in the same cycle as the control pins that set it. The data word is due one cycle after the edge that captured it: the read of the address, or the write that preloaded it. The bench applies every stimulus on the falling edge and samples 1 ns later. At that point the flag reflects the new controls, and the data reflects the registers loaded at the previous rising edge. Each expected value in the vector table, and in the fill-and-readback sweep, is worked out on that basis. In the sweep, each read cycle is checked against the address of the cycle before it. The first read after the final write is checked against the preloaded word.

// File: rtl/sram_pkg.sv
package sram_pkg;
  typedef enum logic [2:0] {
    MODE_IDLE_HI = 3'd0,
    MODE_IDLE_LO = 3'd1,
    MODE_MUTE    = 3'd2,
    MODE_READ    = 3'd3,
    MODE_WRITE   = 3'd4
  } mode_t;
endpackage

// File: rtl/sram_mode_decode.sv
module sram_mode_decode
  import sram_pkg::*;
(
  input  logic  cs_lo_n,
  input  logic  cs_hi,
  input  logic  wr_n,
  input  logic  oe_n,
  output mode_t mode
);
  always_comb begin
    if (!cs_hi)       mode = MODE_IDLE_HI;
    else if (cs_lo_n) mode = MODE_IDLE_LO;
    else if (!wr_n)   mode = MODE_WRITE;
    else if (!oe_n)   mode = MODE_READ;
    else              mode = MODE_MUTE;
  end
endmodule

// File: rtl/sram_store.sv
module sram_store #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] rd_word
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) cells[addr] <= din;
  end

  assign rd_word = cells[addr];

  // R4
  write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> cells[$past(addr)] == $past(din));
endmodule

// File: rtl/sram_out_stage.sv
module sram_out_stage
  import sram_pkg::*;
#(
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  mode_t             mode,
  input  logic [DATA_W-1:0] din,
  input  logic [DATA_W-1:0] rd_word,
  output logic [DATA_W-1:0] dout,
  output logic              dout_drive
);
  logic [DATA_W-1:0] hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  hold_q <= '0;
    else if (mode == MODE_WRITE) hold_q <= din;
    else if (mode == MODE_READ)  hold_q <= rd_word;
  end

  assign dout_drive = (mode == MODE_READ);
  assign dout       = dout_drive ? hold_q : '0;

  // R6
  write_preload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_WRITE) |=> hold_q == $past(din));

  // R5
  read_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_READ) |=> hold_q == $past(rd_word));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != MODE_READ && mode != MODE_WRITE) |=> $stable(hold_q));
endmodule

// File: rtl/sram_dual_sel.sv
module sram_dual_sel
  import sram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  input  logic              cs_lo_n,
  input  logic              cs_hi,
  input  logic              wr_n,
  input  logic              oe_n,
  output logic [DATA_W-1:0] dout,
  output logic              dout_drive
);
  mode_t             mode;
  logic [DATA_W-1:0] rd_word;

  sram_mode_decode u_dec (
    .cs_lo_n (cs_lo_n),
    .cs_hi   (cs_hi),
    .wr_n    (wr_n),
    .oe_n    (oe_n),
    .mode    (mode)
  );

  sram_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (mode == MODE_WRITE),
    .addr    (addr),
    .din     (din),
    .rd_word (rd_word)
  );

  sram_out_stage #(.DATA_W(DATA_W)) u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode       (mode),
    .din        (din),
    .rd_word    (rd_word),
    .dout       (dout),
    .dout_drive (dout_drive)
  );

  // R1
  hi_sel_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_hi |-> !dout_drive);

  // R2
  lo_sel_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_lo_n |-> !dout_drive);

  // R4
  write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_hi && !cs_lo_n && !wr_n) |-> !dout_drive);

  // R7
  undriven_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_drive |-> dout == '0);
endmodule

// File: tb/sram_dual_sel_test.sv
`timescale 1ns/1ps
module sram_dual_sel_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] addr = '0;
  logic [3:0] din = '0;
  logic       cs_lo_n = 1'b1, cs_hi = 1'b0, wr_n = 1'b1, oe_n = 1'b1;
  logic [3:0] dout;
  logic       dout_drive;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  sram_dual_sel uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .din(din),
    .cs_lo_n(cs_lo_n), .cs_hi(cs_hi), .wr_n(wr_n), .oe_n(oe_n),
    .dout(dout), .dout_drive(dout_drive)
  );

  // {cs_lo_n, cs_hi, wr_n, oe_n, addr, din, exp_drive, exp_dout}
  localparam int NV = 15;
  localparam logic [20:0] VEC [NV] = '{
    {4'b0100, 8'h10, 4'h5, 1'b0, 4'h0},  // R4 write, oe low
    {4'b0110, 8'h10, 4'h0, 1'b1, 4'h5},  // R6 preload
    {4'b0101, 8'h20, 4'hA, 1'b0, 4'h0},  // R4 write, oe high
    {4'b0100, 8'h21, 4'h3, 1'b0, 4'h0},  // R4
    {4'b0110, 8'h20, 4'h0, 1'b1, 4'h3},  // R6 preload of last write
    {4'b0110, 8'h20, 4'h0, 1'b1, 4'hA},  // R5
    {4'b0110, 8'h21, 4'h0, 1'b1, 4'hA},  // R5 one-cycle lag
    {4'b0000, 8'h20, 4'hF, 1'b0, 4'h0},  // R1
    {4'b1100, 8'h21, 4'hC, 1'b0, 4'h0},  // R2
    {4'b0111, 8'h20, 4'h0, 1'b0, 4'h0},  // R3
    {4'b0110, 8'h20, 4'h0, 1'b1, 4'h3},  // R10 hold kept
    {4'b0110, 8'h21, 4'h0, 1'b1, 4'hA},  // R1 no write of F
    {4'b0110, 8'h21, 4'h0, 1'b1, 4'h3},  // R2 no write of C
    {4'b0100, 8'h10, 4'h9, 1'b0, 4'h0},  // R4 overwrite
    {4'b0110, 8'h10, 4'h0, 1'b1, 4'h9}   // R6
  };

  task automatic check(input string req, input logic ed, input logic [3:0] ev);
    n_chk++;
    if (dout_drive !== ed || dout !== ev) begin
      n_fail++;
      $display("FAIL %s: drive=%0b dout=%h, expected drive=%0b dout=%h",
               req, dout_drive, dout, ed, ev);
    end
  endtask

  task automatic apply(input logic [3:0] ctl, input logic [7:0] a, input logic [3:0] d);
    @(negedge clk);
    {cs_lo_n, cs_hi, wr_n, oe_n} = ctl;
    addr = a;
    din  = d;
    #1;
  endtask

  function automatic logic [3:0] pat(input int i);
    return 4'(i) ^ 4'(i >> 4) ^ 4'h6;
  endfunction

  initial begin
    #150000;
    n_fail++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R8: read straight after reset
    apply(4'b0110, 8'h00, 4'h0);
    check("R8", 1'b1, 4'h0);
    apply(4'b1111, 8'h00, 4'h0);
    check("R7", 1'b0, 4'h0);

    for (int v = 0; v < NV; v++) begin
      apply(VEC[v][20:17], VEC[v][16:9], VEC[v][8:5]);
      check($sformatf("R%0s vec%0d", "x", v), VEC[v][4], VEC[v][3:0]);
    end

    // R9: fill every address, then sweep reads
    for (int i = 0; i < 256; i++) begin
      apply(4'b0101, 8'(i), pat(i));
      if (i == 0 || i == 255) check("R4", 1'b0, 4'h0);
    end
    for (int i = 0; i < 256; i++) begin
      apply(4'b0110, 8'(i), 4'h0);
      if (i == 0) check("R6", 1'b1, pat(255));
      else        check("R9", 1'b1, pat(i - 1));
    end
    apply(4'b0111, 8'h00, 4'h0);
    check("R3", 1'b0, 4'h0);
    apply(4'b0110, 8'hFF, 4'h0);
    check("R10", 1'b1, pat(255));

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule